// File: doc/BRIEF.md
# Transmit/Receive Switch Delay Controller

This block drives the antenna switch select of a radio front end. A level input reports whether the transmit datapath is busy. The switch output follows that level, but each direction of change has its own programmable wait. The wait before switching to transmit lets the switch line up with the latency of the transmitter pipeline. The wait before switching back to receive lets the last samples leave the antenna before the receiver is connected again.

The two wait lengths live in two configuration registers. A host writes them through a narrow write port that has a strobe, an address and a data word. A four-state controller and a single shared down-counter time both waits. A new register value is used from the next time the counter is loaded, so a write never disturbs a wait that is already running.

Top module: `trsw_delay`

## Requirements
- R1: While `rst_n` is low and after reset is released, `sw_tx` is 0 (receive). Both wait registers hold 0 after reset.
- R2: A cycle with `cfg_wr` high and `cfg_addr` equal to 2 stores `cfg_data[11:0]` as the transmit wait. Bits above 11 are discarded.
- R3: A cycle with `cfg_wr` high and `cfg_addr` equal to 3 stores `cfg_data[11:0]` as the receive wait. A write to any other address changes neither register, including addresses whose low bits match 2 or 3, such as 66 and 67.
- R4: Let `sw_tx` be 0 and let `tx_busy` first be sampled high at rising edge k, with transmit wait T. If `tx_busy` is also sampled high at every edge up to and including edge k+T+1, then `sw_tx` becomes 1 right after edge k+T+1 and not earlier.
- R5: Let `sw_tx` be 1 and let `tx_busy` first be sampled low at edge k, with receive wait R. If `tx_busy` is also sampled low at every edge up to and including edge k+R+1, then `sw_tx` becomes 0 right after edge k+R+1.
- R6: With a wait of 0, the output follows `tx_busy` with a lag of exactly one edge after the edge that first samples the new level.
- R7: If `tx_busy` is sampled low at any edge from k+1 to k+T+1 during a transmit wait, `sw_tx` stays 0 and the controller returns to idle. The next transmit request then starts a fresh wait.
- R8: If `tx_busy` is sampled high during a receive wait, before the wait completes, `sw_tx` stays 1 without a glitch. A later drop of `tx_busy` starts a fresh, full receive wait.
- R9: A write to a wait register while that wait is counting does not change the wait in progress. The new value applies from the next load.
- R10: The full 12-bit range works, up to a wait of 4095 cycles, and the counter never wraps below zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register write address |
| cfg_data | input | 32 | Register write data, low 12 bits used |
| tx_busy | input | 1 | Transmit datapath active level |
| sw_tx | output | 1 | Switch select: 1 = transmit, 0 = receive |

## Verification
The bench targets the exact edges of both waits. It holds `tx_busy` for exactly T+2 and T+1 sampled edges, and drops it for exactly R+2 and R+1 edges. An off-by-one in the counter would then show up in one of two ways: the switch would move a cycle early, or a burst that should have switched would be treated as an abort. It also runs abort and re-entry bursts. A controller that mishandled these would pulse `sw_tx` high on a short burst, or glitch it low when the transmitter resumes. Register writes go to addresses whose low bits alias the real ones, carry data with the upper bits set, and land in the middle of a running wait. A loose address decode, a missing bit mask or a counter that reloads on every write would each shift a later switching edge.

// File: rtl/trsw_pkg.sv
package trsw_pkg;

   typedef enum logic [1:0] {
      ST_RX_HOLD  = 2'd0,
      ST_TX_WAIT  = 2'd1,
      ST_TX_HOLD  = 2'd2,
      ST_RX_WAIT  = 2'd3
   } trsw_state_e;

   localparam int unsigned N_WAIT_REGS = 2;
   localparam int unsigned IDX_TX      = 0;
   localparam int unsigned IDX_RX      = 1;

endpackage

// File: rtl/trsw_regs.sv
module trsw_regs #(
   parameter int unsigned ADDR_W  = 7,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned DLY_W   = 12,
   parameter int unsigned TX_ADDR = 2,
   parameter int unsigned RX_ADDR = 3
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        wr,
   input  logic [ADDR_W-1:0]                           addr,
   input  logic [DATA_W-1:0]                           data,
   output logic [trsw_pkg::N_WAIT_REGS-1:0][DLY_W-1:0] dly
);
   import trsw_pkg::*;

   initial begin
      assert (DLY_W >= 1 && DLY_W <= DATA_W)
         else $error("trsw_regs: DLY_W must be within 1..DATA_W");
      assert (TX_ADDR != RX_ADDR)
         else $error("trsw_regs: register addresses must differ");
      assert (TX_ADDR < (1 << ADDR_W) && RX_ADDR < (1 << ADDR_W))
         else $error("trsw_regs: address does not fit ADDR_W");
   end

   for (genvar g = 0; g < N_WAIT_REGS; g++) begin : g_reg
      localparam logic [ADDR_W-1:0] MY_ADDR =
         (g == IDX_TX) ? ADDR_W'(TX_ADDR) : ADDR_W'(RX_ADDR);

      logic             hit;
      logic [DLY_W-1:0] q;

      assign hit = wr && (addr == MY_ADDR);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (hit) begin
            q <= data[DLY_W-1:0];
         end
      end

      assign dly[g] = q;

      // R2 / R3: a matching write stores the low data bits
      p_reg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && addr == MY_ADDR) |=> (dly[g] == $past(data[DLY_W-1:0])));

      // R3: any other cycle leaves the register untouched
      p_reg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr && addr == MY_ADDR) |=> $stable(dly[g]));
   end

endmodule

// File: rtl/trsw_cnt.sv
module trsw_cnt #(
   parameter int unsigned DLY_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] load_val,
   input  logic             dec,
   output logic             zero
);

   initial begin
      assert (DLY_W >= 1 && DLY_W <= 31)
         else $error("trsw_cnt: DLY_W out of range");
   end

   logic [DLY_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (dec) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign zero = (cnt == '0);

   // R10: the controller never asks for a step below zero
   p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> !zero);

   // R9: a load takes exactly the value presented at that edge
   p_load_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)));

   p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !dec) |=> $stable(cnt));

endmodule

// File: rtl/trsw_fsm.sv
module trsw_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_busy,
   input  logic zero,
   output logic load,
   output logic sel_rx,
   output logic dec,
   output logic sw_tx
);
   import trsw_pkg::*;

   trsw_state_e st, nxt;

   always_comb begin
      nxt    = st;
      load   = 1'b0;
      sel_rx = 1'b0;
      dec    = 1'b0;
      unique case (st)
         ST_RX_HOLD: begin
            if (tx_busy) begin
               load = 1'b1;
               nxt  = ST_TX_WAIT;
            end
         end
         ST_TX_WAIT: begin
            if (!tx_busy)  nxt = ST_RX_HOLD;
            else if (zero) nxt = ST_TX_HOLD;
            else           dec = 1'b1;
         end
         ST_TX_HOLD: begin
            if (!tx_busy) begin
               load   = 1'b1;
               sel_rx = 1'b1;
               nxt    = ST_RX_WAIT;
            end
         end
         ST_RX_WAIT: begin
            if (tx_busy)   nxt = ST_TX_HOLD;
            else if (zero) nxt = ST_RX_HOLD;
            else           dec = 1'b1;
         end
         default: nxt = ST_RX_HOLD;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_RX_HOLD;
         sw_tx <= 1'b0;
      end else begin
         st    <= nxt;
         sw_tx <= (nxt == ST_TX_HOLD) || (nxt == ST_RX_WAIT);
      end
   end

   // R4: transmit is only entered at the end of a transmit wait
   p_rise_after_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_tx) |-> ($past(st) == ST_TX_WAIT && $past(tx_busy)));

   // R5: receive is only re-entered at the end of a receive wait
   p_fall_after_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_tx) |-> ($past(st) == ST_RX_WAIT && !$past(tx_busy)));

   // R6: an expired wait switches on the following edge
   p_switch_on_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TX_WAIT && tx_busy && zero) |=> sw_tx);

   // R7: dropping the request during a transmit wait aborts it
   p_abort_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TX_WAIT && !tx_busy) |=> (st == ST_RX_HOLD && !sw_tx));

   // R8: a renewed request during a receive wait keeps transmit
   p_reenter_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RX_WAIT && tx_busy) |=> (st == ST_TX_HOLD && sw_tx));

endmodule

// File: rtl/trsw_delay.sv
module trsw_delay #(
   parameter int unsigned ADDR_W  = 7,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned DLY_W   = 12,
   parameter int unsigned TX_ADDR = 2,
   parameter int unsigned RX_ADDR = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_data,
   input  logic              tx_busy,
   output logic              sw_tx
);
   import trsw_pkg::*;

   logic [N_WAIT_REGS-1:0][DLY_W-1:0] dly;
   logic                              load, sel_rx, dec, zero;
   logic [DLY_W-1:0]                  load_val;

   trsw_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .DLY_W  (DLY_W),
      .TX_ADDR(TX_ADDR),
      .RX_ADDR(RX_ADDR)
   ) i_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (cfg_wr),
      .addr (cfg_addr),
      .data (cfg_data),
      .dly  (dly)
   );

   assign load_val = sel_rx ? dly[IDX_RX] : dly[IDX_TX];

   trsw_cnt #(
      .DLY_W(DLY_W)
   ) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .load_val(load_val),
      .dec     (dec),
      .zero    (zero)
   );

   trsw_fsm i_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .tx_busy(tx_busy),
      .zero   (zero),
      .load   (load),
      .sel_rx (sel_rx),
      .dec    (dec),
      .sw_tx  (sw_tx)
   );

   // R1: receive is selected in the first cycle after reset
   p_reset_rx_r1: assert property (@(posedge clk)
      !rst_n |=> !sw_tx);

endmodule

// File: tb/test_trsw_delay.sv
`timescale 1ns/1ps
module test_trsw_delay;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr;
   logic [6:0]  cfg_addr;
   logic [31:0] cfg_data;
   logic        tx_busy;
   logic        sw_tx;

   always #5 clk = ~clk;

   trsw_delay i_trsw_delay (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_wr  (cfg_wr),
      .cfg_addr(cfg_addr),
      .cfg_data(cfg_data),
      .tx_busy (tx_busy),
      .sw_tx   (sw_tx)
   );

   typedef struct {
      int unsigned cyc;
      logic        val;
      string       tag;
   } exp_t;

   exp_t        exp_q[$];
   int unsigned cyc    = 0;
   int          n_cmp  = 0;
   int          n_bad  = 0;
   bit          mon_en = 1'b0;
   bit          done   = 1'b0;
   logic        prev   = 1'b0;
   int unsigned dt     = 0;
   int unsigned dr     = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: every change of sw_tx must match the next expected item
   always @(negedge clk) begin
      exp_t x;
      if (mon_en && sw_tx !== prev) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R4: sw_tx changed to %0b at cycle %0d, expected no change",
                     sw_tx, cyc);
         end else begin
            x = exp_q.pop_front();
            if (x.cyc != cyc || x.val !== sw_tx) begin
               n_bad++;
               $display("FAIL %s: sw_tx=%0b at cycle %0d, expected %0b at cycle %0d",
                        x.tag, sw_tx, cyc, x.val, x.cyc);
            end
         end
         prev = sw_tx;
      end
   end

   task automatic push(input int unsigned c, input logic v, input string tag);
      exp_t x;
      x.cyc = c;
      x.val = v;
      x.tag = tag;
      exp_q.push_back(x);
   endtask

   task automatic check_level(input logic e, input string tag);
      n_cmp++;
      if (sw_tx !== e) begin
         n_bad++;
         $display("FAIL %s: sw_tx=%0b, expected %0b", tag, sw_tx, e);
      end
   endtask

   task automatic write_reg(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_wr   = 1'b1;
      cfg_addr = a;
      cfg_data = d;
      @(negedge clk);
      cfg_wr   = 1'b0;
   endtask

   // request high for h sampled edges, then low for l edges
   task automatic burst(input int unsigned h, input int unsigned l, input string tag);
      int unsigned e, f;
      bit          up;
      @(negedge clk);
      e       = cyc + 1;
      tx_busy = 1'b1;
      up      = (h >= dt + 2);
      if (up) push(e + dt + 1, 1'b1, tag);
      repeat (h) @(negedge clk);
      f       = cyc + 1;
      tx_busy = 1'b0;
      if (up && l >= dr + 2) push(f + dr + 1, 1'b0, tag);
      repeat (l) @(negedge clk);
      check_level(1'b0, tag);
   endtask

   // R8: short gap inside the receive wait, then a second burst
   task automatic burst_gap(input int unsigned h1, input int unsigned g,
                            input int unsigned h2, input int unsigned l);
      int unsigned e, f;
      @(negedge clk);
      e       = cyc + 1;
      tx_busy = 1'b1;
      push(e + dt + 1, 1'b1, "R8");
      repeat (h1) @(negedge clk);
      tx_busy = 1'b0;
      repeat (g) @(negedge clk);
      tx_busy = 1'b1;
      repeat (h2) @(negedge clk);
      check_level(1'b1, "R8");
      f       = cyc + 1;
      tx_busy = 1'b0;
      push(f + dr + 1, 1'b0, "R8");
      repeat (l) @(negedge clk);
      check_level(1'b0, "R8");
   endtask

   // R9: rewrite the transmit wait while it is counting
   task automatic burst_midwrite(input int unsigned h, input int unsigned l,
                                 input int unsigned nv);
      int unsigned e, f;
      @(negedge clk);
      e       = cyc + 1;
      tx_busy = 1'b1;
      push(e + dt + 1, 1'b1, "R9");
      @(negedge clk);
      cfg_wr   = 1'b1;
      cfg_addr = 7'd2;
      cfg_data = 32'(nv);
      @(negedge clk);
      cfg_wr   = 1'b0;
      repeat (h - 2) @(negedge clk);
      dt      = nv;
      f       = cyc + 1;
      tx_busy = 1'b0;
      push(f + dr + 1, 1'b0, "R9");
      repeat (l) @(negedge clk);
      check_level(1'b0, "R9");
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         report();
      end
   end

   initial begin
      rst_n    = 1'b0;
      cfg_wr   = 1'b0;
      cfg_addr = '0;
      cfg_data = '0;
      tx_busy  = 1'b0;
      repeat (3) @(negedge clk);
      check_level(1'b0, "R1 in reset");
      rst_n  = 1'b1;
      prev   = 1'b0;
      mon_en = 1'b1;
      repeat (2) @(negedge clk);
      check_level(1'b0, "R1 after reset");

      // R1/R6: reset waits are zero, output lags by one edge
      burst(4, 5, "R6");
      burst(1, 4, "R7");                 // one edge: too short even at zero

      // R2: upper data bits discarded, transmit wait = 3
      write_reg(7'd2, 32'hABCD_E003);
      dt = 3;
      write_reg(7'd3, 32'd5);            // R3: receive wait = 5
      dr = 5;
      burst(8, 9, "R4");

      // R3: aliasing and unrelated addresses leave the waits alone
      write_reg(7'd66, 32'd9);
      write_reg(7'd67, 32'd1);
      write_reg(7'd0,  32'd11);
      burst(5, 7, "R3");                 // exact boundaries T+2 and R+2
      burst(5, 7, "R5");

      // R7: request ends one edge before the wait completes
      burst(4, 8, "R7");

      // R8: gap of R+1 edges keeps transmit
      burst_gap(6, 6, 3, 8);

      // R9: write in the middle of a wait, then the next burst uses it
      burst_midwrite(10, 8, 7);
      burst(12, 8, "R9");

      // R10: largest wait
      write_reg(7'd2, 32'h0000_0FFF);
      dt = 4095;
      burst(4100, 8, "R10");

      write_reg(7'd2, 32'd0);
      write_reg(7'd3, 32'd0);
      dt = 0;
      dr = 0;
      burst(3, 3, "R6");

      repeat (5) @(negedge clk);
      n_cmp++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R4: %0d expected switch events never seen, expected 0",
                  exp_q.size());
      end
      done = 1'b1;
      report();
   end

endmodule